// File: doc/BRIEF.md
# Approximate Pattern Scanner

This block watches a byte stream, one character per clock, and reports whether the current packet contains a fixed pattern within a bounded edit distance. An edit is one of three things: a character that differs from the pattern, an extra character in the stream, or a pattern character missing from the stream. Each edit costs one, and the pattern is reported as found when some stretch of the packet can be turned into the pattern with no more than `MAX_ERR` edits. The pattern may start at any byte offset in the packet.

The pattern text, its length and the edit budget are elaboration-time parameters. Internally the block keeps `MAX_ERR + 1` rows of state, each as wide as the pattern. Bit `j` of row `e` is set when the first `j + 1` pattern characters can be aligned to the stream ending at the latest character using at most `e` edits. A beat flagged as the start of a packet is processed as the first character of a fresh packet with all rows cleared. The found flag is registered, so it rises in the cycle after the character that completes the match. It then stays high until the next start-of-packet beat.

Top module: `fuzzy_pattern_scan`

## Requirements
- R1: After synchronous reset, `match_o` is low.
- R2: An exact copy of the pattern anywhere inside a packet, including at the first beat, raises `match_o` in the cycle after the beat that carries its last character.
- R3: With `MAX_ERR` = 1, a pattern copy with one character replaced by another is reported as a match.
- R4: With `MAX_ERR` = 1, a pattern copy with one extra character inserted inside it is reported as a match.
- R5: With `MAX_ERR` = 1, a pattern copy with one interior character missing is reported as a match.
- R6: A stretch that needs more than `MAX_ERR` edits (for example two replaced characters with `MAX_ERR` = 1) does not raise `match_o`.
- R7: Once high, `match_o` stays high on later beats of the same packet. It follows only the new packet's content from the start-of-packet beat onward.
- R8: No partial match carries across a packet boundary. A start-of-packet beat clears all rows before it is processed.
- R9: Cycles with `valid_i` low change neither the rows nor `match_o`. A pattern split by idle cycles still matches.
- R10: With `MAX_ERR` = 0 only exact copies match. A copy with one replaced, inserted or missing character is not reported.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| valid_i | input | 1 | A character is present on `char_i` this cycle |
| sop_i | input | 1 | With `valid_i`, this character is the first of a new packet |
| char_i | input | 8 | Input character |
| match_o | output | 1 | Pattern found within the edit budget in the current packet; held until the next packet starts |

## Verification
Some behaviours are checked on every cycle by assertions: the found flag holding within a packet, idle cycles leaving the rows and the flag untouched, a start-of-packet beat clearing every row above the first position, each exact-match bit agreeing with the character just consumed, and each row being contained in the row with one more edit allowed. Other behaviours can only be shown by the directed scenarios. These are whether a particular replaced, inserted or missing character is tolerated, whether a double edit is rejected, and whether a zero-edit instance stays exact. They cover both instance variants and also show that no partial match survives a packet boundary.

// File: rtl/fps_pkg.sv
package fps_pkg;

    typedef logic [7:0] char_t;

    typedef struct packed {
        logic  valid;
        logic  sop;
        char_t ch;
    } beat_t;

    typedef enum logic [1:0] {
        HOLD_KEEP  = 2'd0,
        HOLD_FRESH = 2'd1,
        HOLD_ACCUM = 2'd2
    } hold_mode_e;

    function automatic logic beat_starts(beat_t b);
        return b.valid && b.sop;
    endfunction

    function automatic hold_mode_e hold_mode(beat_t b);
        if (!b.valid)
            return HOLD_KEEP;
        else if (b.sop)
            return HOLD_FRESH;
        else
            return HOLD_ACCUM;
    endfunction

endpackage

// File: rtl/fps_char_decode.sv
module fps_char_decode
    import fps_pkg::*;
#(
    parameter int unsigned           PAT_LEN = 4,
    parameter logic [PAT_LEN*8-1:0]  PATTERN = "ABCD"
) (
    input  char_t              ch_i,
    output logic [PAT_LEN-1:0] hit_o
);

    // Position j is pattern character j, the first character at the top byte.
    for (genvar j = 0; j < PAT_LEN; j++) begin : g_pos
        assign hit_o[j] = (ch_i == PATTERN[(PAT_LEN-1-j)*8 +: 8]);
    end

endmodule

// File: rtl/fps_row_update.sv
module fps_row_update #(
    parameter int unsigned PAT_LEN   = 4,
    parameter bit          HAS_LOWER = 1'b1
) (
    input  logic [PAT_LEN-1:0] own_old_i,
    input  logic [PAT_LEN-1:0] lower_old_i,
    input  logic [PAT_LEN-1:0] lower_new_i,
    input  logic [PAT_LEN-1:0] hit_i,
    output logic [PAT_LEN-1:0] own_new_o
);

    localparam logic ENTRY = HAS_LOWER;

    logic [PAT_LEN-1:0] advance;
    logic [PAT_LEN-1:0] replaced;
    logic [PAT_LEN-1:0] skipped;

    // Matching character: move one position on; the empty prefix is always live.
    assign advance  = {own_old_i[PAT_LEN-2:0], 1'b1} & hit_i;
    // Replacement: one position on from the cheaper row, whatever the character.
    assign replaced = {lower_old_i[PAT_LEN-2:0], ENTRY};
    // Missing pattern character: one position on from the cheaper row's new state.
    assign skipped  = {lower_new_i[PAT_LEN-2:0], ENTRY};

    // An extra stream character leaves the cheaper row's position unchanged.
    assign own_new_o = advance | lower_old_i | replaced | skipped;

endmodule

// File: rtl/fps_match_hold.sv
module fps_match_hold
    import fps_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  beat_t beat_i,
    input  logic  found_i,
    output logic  match_o
);

    hold_mode_e mode;
    assign mode = hold_mode(beat_i);

    always_ff @(posedge clk) begin
        if (rst) begin
            match_o <= 1'b0;
        end else begin
            unique case (mode)
                HOLD_FRESH: match_o <= found_i;
                HOLD_ACCUM: match_o <= match_o | found_i;
                default:    match_o <= match_o;
            endcase
        end
    end

    // R7: a reported match persists until a new packet begins
    assert_match_sticky_R7: assert property (@(posedge clk) disable iff (rst)
        (match_o && !beat_starts(beat_i)) |=> match_o)
        else $error("match dropped inside a packet");

endmodule

// File: rtl/fuzzy_pattern_scan.sv
module fuzzy_pattern_scan
    import fps_pkg::*;
#(
    parameter int unsigned           PAT_LEN = 4,
    parameter int unsigned           MAX_ERR = 1,
    parameter logic [PAT_LEN*8-1:0]  PATTERN = "ABCD"
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       valid_i,
    input  logic       sop_i,
    input  logic [7:0] char_i,
    output logic       match_o
);

    localparam int unsigned ROWS = MAX_ERR + 1;

    beat_t                          beat;
    logic [PAT_LEN-1:0]             hit;
    logic [ROWS-1:0][PAT_LEN-1:0]   rows_q;
    logic [ROWS-1:0][PAT_LEN-1:0]   rows_base;
    logic [ROWS-1:0][PAT_LEN-1:0]   rows_next;
    logic [ROWS-1:0]                last_bits;
    logic                           found;

    assign beat      = '{valid: valid_i, sop: sop_i, ch: char_i};
    assign rows_base = beat_starts(beat) ? '0 : rows_q;

    fps_char_decode #(
        .PAT_LEN (PAT_LEN),
        .PATTERN (PATTERN)
    ) i_decode (
        .ch_i  (beat.ch),
        .hit_o (hit)
    );

    for (genvar e = 0; e < ROWS; e++) begin : g_row
        if (e == 0) begin : g_exact
            fps_row_update #(
                .PAT_LEN   (PAT_LEN),
                .HAS_LOWER (1'b0)
            ) i_row (
                .own_old_i   (rows_base[0]),
                .lower_old_i ('0),
                .lower_new_i ('0),
                .hit_i       (hit),
                .own_new_o   (rows_next[0])
            );
        end else begin : g_edit
            fps_row_update #(
                .PAT_LEN   (PAT_LEN),
                .HAS_LOWER (1'b1)
            ) i_row (
                .own_old_i   (rows_base[e]),
                .lower_old_i (rows_base[e-1]),
                .lower_new_i (rows_next[e-1]),
                .hit_i       (hit),
                .own_new_o   (rows_next[e])
            );
        end
        assign last_bits[e] = rows_next[e][PAT_LEN-1];
    end

    assign found = |last_bits;

    always_ff @(posedge clk) begin
        if (rst)
            rows_q <= '0;
        else if (valid_i)
            rows_q <= rows_next;
    end

    fps_match_hold i_hold (
        .clk     (clk),
        .rst     (rst),
        .beat_i  (beat),
        .found_i (found),
        .match_o (match_o)
    );

    // R9: idle cycles leave the rows and the flag alone
    assert_idle_stable_R9: assert property (@(posedge clk) disable iff (rst)
        !valid_i |=> ($stable(rows_q) && $stable(match_o)))
        else $error("state moved on an idle cycle");

    // R8: a packet start wipes every exact-match position beyond the first
    assert_sop_clears_R8: assert property (@(posedge clk) disable iff (rst)
        (valid_i && sop_i) |=> (rows_q[0][PAT_LEN-1:1] == '0))
        else $error("exact row kept state across a packet start");

    // R2: an exact-match bit implies the consumed character equals that pattern position
    for (genvar j = 0; j < PAT_LEN; j++) begin : g_chk_pos
        assert_exact_char_R2: assert property (@(posedge clk) disable iff (rst)
            valid_i |=> (!rows_q[0][j] || ($past(char_i) == PATTERN[(PAT_LEN-1-j)*8 +: 8])))
            else $error("exact row bit set on wrong character");
    end

    // R3: a row allowing more edits always covers the row allowing fewer
    for (genvar e = 0; e + 1 < ROWS; e++) begin : g_chk_nest
        assert_rows_nested_R3: assert property (@(posedge clk) disable iff (rst)
            ((rows_q[e] & ~rows_q[e+1]) == '0))
            else $error("edit rows not nested");
    end

endmodule

// File: tb/test_fuzzy_pattern_scan.sv
`timescale 1ns/1ps
module test_fuzzy_pattern_scan;

    logic       clk = 1'b0;
    logic       rst;
    logic       valid_i;
    logic       sop_i;
    logic [7:0] char_i;
    logic       match_o;
    logic       match_exact;

    int checks = 0;
    int fails  = 0;

    always #2.5 clk = ~clk;

    fuzzy_pattern_scan #(.PAT_LEN(4), .MAX_ERR(1), .PATTERN("ABCD")) i_fuzzy_pattern_scan (
        .clk(clk), .rst(rst), .valid_i(valid_i), .sop_i(sop_i),
        .char_i(char_i), .match_o(match_o)
    );

    fuzzy_pattern_scan #(.PAT_LEN(4), .MAX_ERR(0), .PATTERN("ABCD")) i_fuzzy_pattern_scan_exact (
        .clk(clk), .rst(rst), .valid_i(valid_i), .sop_i(sop_i),
        .char_i(char_i), .match_o(match_exact)
    );

    task automatic check(string req, string what, logic got, logic exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s %s: got %0b expected %0b", req, what, got, exp);
        end
    endtask

    // Inputs are driven right after a falling edge; the design samples them at the next rise.
    task automatic send(string s, bit first_is_sop);
        for (int i = 0; i < s.len(); i++) begin
            valid_i = 1'b1;
            sop_i   = first_is_sop && (i == 0);
            char_i  = s[i];
            @(negedge clk);
        end
        valid_i = 1'b0;
        sop_i   = 1'b0;
    endtask

    task automatic idle(int n);
        valid_i = 1'b0;
        sop_i   = 1'b0;
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic t_reset;
        rst = 1'b1; valid_i = 1'b0; sop_i = 1'b0; char_i = 8'h00;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1", "flag after reset", match_o, 1'b0);
        check("R1", "exact flag after reset", match_exact, 1'b0);
    endtask

    task automatic t_exact;
        send("xxABCDyy", 1'b1);
        check("R2", "embedded exact copy", match_o, 1'b1);
        check("R2", "embedded exact copy, zero-edit", match_exact, 1'b1);
        send("ABC", 1'b1);
        check("R2", "prefix only, zero-edit", match_exact, 1'b0);
        send("D", 1'b0);
        check("R2", "copy at packet start", match_exact, 1'b1);
    endtask

    task automatic t_substitute;
        send("qABXDq", 1'b1);
        check("R3", "one replaced char", match_o, 1'b1);
        check("R10", "one replaced char, zero-edit", match_exact, 1'b0);
    endtask

    task automatic t_insert;
        send("qABZCDq", 1'b1);
        check("R4", "one extra char", match_o, 1'b1);
        check("R10", "one extra char, zero-edit", match_exact, 1'b0);
    endtask

    task automatic t_delete;
        send("qABDq", 1'b1);
        check("R5", "one missing char", match_o, 1'b1);
        check("R10", "one missing char, zero-edit", match_exact, 1'b0);
    endtask

    task automatic t_too_many;
        send("qAXYDq", 1'b1);
        check("R6", "two replaced chars", match_o, 1'b0);
        send("qABq", 1'b1);
        check("R6", "two missing chars", match_o, 1'b0);
    endtask

    task automatic t_sticky;
        send("ABCD", 1'b1);
        check("R7", "match raised", match_o, 1'b1);
        send("qqqqq", 1'b0);
        check("R7", "held over later beats", match_o, 1'b1);
        send("qq", 1'b1);
        check("R7", "cleared by new packet", match_o, 1'b0);
    endtask

    task automatic t_boundary;
        send("qqAB", 1'b1);
        check("R8", "first half alone", match_o, 1'b0);
        send("CDqq", 1'b1);
        check("R8", "second half in next packet", match_o, 1'b0);
    endtask

    task automatic t_idle;
        send("qAB", 1'b1);
        idle(4);
        check("R9", "partial across idle", match_o, 1'b0);
        send("CD", 1'b0);
        check("R9", "resumed after idle", match_o, 1'b1);
        check("R9", "resumed after idle, zero-edit", match_exact, 1'b1);
        idle(3);
        check("R9", "idle keeps flag", match_o, 1'b1);
    endtask

    initial begin
        t_reset;
        t_exact;
        t_substitute;
        t_insert;
        t_delete;
        t_too_many;
        t_sticky;
        t_boundary;
        t_idle;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        #(200000 * 5);
        checks++;
        fails++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule